// File: doc/BRIEF.md
# 64b/66b Control Block Encoder

This block takes one 64-bit transmit word per clock, presented as eight byte lanes that each carry a control flag. It turns the word into a 66-bit line block. Each block has a 2-bit sync header. An all-data word becomes a block with the data header and the eight bytes unchanged. An all-control word becomes a block with the control header, a type byte and eight 7-bit control codes.

Every field is placed on the output bus at its final serial position, least significant bit first. Bit k of the output is the k-th bit to go out on the line, and lane 0 is sent first. A later stage can therefore shift the bus out with fixed wiring and no reordering, and each 7-bit code stays contiguous on the line. Words that mix data and control lanes need block types that this block does not support. Such a word is replaced by an all-control block made of error codes.

The output is registered with one cycle of latency and is qualified by a valid signal that follows the input valid.

Top module: `enc64_ctl_blk_enc`

## Requirements
- R1: `vld_o` equals `vld_i` delayed by exactly one clock.
- R2: While `rst_n` is low, `vld_o` is 0 and `blk_o` is all zeros.
- R3: A valid word with `ctl_i == 0` produces `blk_o[0]=0`, `blk_o[1]=1`, and `blk_o[2+8*j+i] = data_i[8*j+i]`: lane j's byte is sent LSB first, with lane 0 first.
- R4: A valid word with `ctl_i == 8'hFF` produces `blk_o[0]=1`, `blk_o[1]=0`, and type value 0x1E LSB first in `blk_o[9:2]`, so the line carries 0,1,1,1,1,0,0,0.
- R5: Control characters map to 7-bit codes as follows: 0x07 gives 0x00, 0xFE gives 0x1E, 0x1C gives 0x2D, 0x3C gives 0x33, 0x7C gives 0x4B, 0xBC gives 0x55, 0xDC gives 0x66, and 0xF7 gives 0x78.
- R6: In an all-control block, lane j's code sits at `blk_o[10+7*j+i] = code_j[i]`, LSB first. For the lanes 07 FE 1C 3C 7C BC DC F7, the block read as bytes after the header is 1e 00 4f 6b b6 ac 9a f1.
- R7: In an all-control word, a lane whose character is not in the R5 set gets the error code 0x1E. The other lanes keep their own codes.
- R8: A valid word whose `ctl_i` is neither 0x00 nor 0xFF produces an all-control block (header 1,0 and type 0x1E) in which all eight codes are 0x1E.
- R9: A cycle with `vld_i` low leaves `blk_o` unchanged at the next edge.
- R10: Whenever `vld_o` is high, the two header bits differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vld_i | input | 1 | Input word valid |
| data_i | input | 64 | Eight byte lanes; lane j is at [8j+7:8j] |
| ctl_i | input | 8 | Per-lane control flag; bit j qualifies lane j |
| vld_o | output | 1 | Output block valid |
| blk_o | output | 66 | Encoded block; bit k is the k-th serial bit |

## Verification
The embedded properties check on every cycle that the valid signal has one cycle of latency, that the output holds while the input is idle, that the header is always legal, that data words pass through unchanged, and that mixed words collapse to error blocks. The exact contents of a control block can only be shown by the bench's scenarios. This covers the code for each character, the serial bit order of the type byte and the codes, the substitution of the error code for an unknown character, and the listed control-word vector. The bench compares every cycle against a behavioural model that builds the block one serial bit at a time.

// File: rtl/enc64_pkg.sv
package enc64_pkg;
  localparam int LANES = 8;
  localparam int CHW   = 8;
  localparam int CODEW = 7;
  localparam int HDRW  = 2;
  localparam int BLKW  = HDRW + LANES * CHW;

  localparam logic [CHW-1:0]   TYPE_ALLCTL = 8'h1E;
  localparam logic [CODEW-1:0] CODE_ERR    = 7'h1E;

  typedef enum logic [1:0] {
    KIND_DATA  = 2'd0,
    KIND_CTL   = 2'd1,
    KIND_MIXED = 2'd2
  } blk_kind_e;

  // Character to 7-bit line code; unknown characters give the error code.
  function automatic logic [CODEW-1:0] ctl_code(input logic [CHW-1:0] ch);
    case (ch)
      8'h07:   ctl_code = 7'h00;
      8'hFE:   ctl_code = 7'h1E;
      8'h1C:   ctl_code = 7'h2D;
      8'h3C:   ctl_code = 7'h33;
      8'h7C:   ctl_code = 7'h4B;
      8'hBC:   ctl_code = 7'h55;
      8'hDC:   ctl_code = 7'h66;
      8'hF7:   ctl_code = 7'h78;
      default: ctl_code = CODE_ERR;
    endcase
  endfunction

  function automatic logic ctl_known(input logic [CHW-1:0] ch);
    case (ch)
      8'h07, 8'hFE, 8'h1C, 8'h3C, 8'h7C, 8'hBC, 8'hDC, 8'hF7: ctl_known = 1'b1;
      default: ctl_known = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/enc64_lane_map.sv
module enc64_lane_map
  import enc64_pkg::*;
#(
  parameter int NL = LANES
) (
  input  logic [NL*CHW-1:0]   chars_i,
  output logic [NL*CODEW-1:0] codes_o,
  output logic [NL-1:0]       known_o
);
  for (genvar j = 0; j < NL; j++) begin : g_lane
    assign codes_o[j*CODEW +: CODEW] = ctl_code(chars_i[j*CHW +: CHW]);
    assign known_o[j]                = ctl_known(chars_i[j*CHW +: CHW]);
  end
endmodule

// File: rtl/enc64_kind.sv
module enc64_kind
  import enc64_pkg::*;
#(
  parameter int NL = LANES
) (
  input  logic [NL-1:0] ctl_i,
  output blk_kind_e     kind_o,
  output logic          all_data_o,
  output logic          all_ctl_o,
  output logic          mixed_o
);
  assign all_data_o = (ctl_i == '0);
  assign all_ctl_o  = (ctl_i == '1);
  assign mixed_o    = !all_data_o && !all_ctl_o;

  always_comb begin
    if (all_data_o)     kind_o = KIND_DATA;
    else if (all_ctl_o) kind_o = KIND_CTL;
    else                kind_o = KIND_MIXED;
  end
endmodule

// File: rtl/enc64_pack.sv
module enc64_pack
  import enc64_pkg::*;
#(
  parameter int NL = LANES
) (
  input  blk_kind_e           kind_i,
  input  logic [NL*CHW-1:0]   data_i,
  input  logic [NL*CODEW-1:0] codes_i,
  output logic [BLKW-1:0]     blk_o
);
  localparam int CODE_BASE = HDRW + CHW;

  logic [BLKW-1:0] data_blk;
  logic [BLKW-1:0] ctl_blk;
  logic [BLKW-1:0] err_blk;

  // Data block: header 0 then 1 on the line, bytes LSB first, lane 0 first.
  assign data_blk[0] = 1'b0;
  assign data_blk[1] = 1'b1;
  assign data_blk[BLKW-1:HDRW] = data_i;

  // Control block: header 1 then 0, type byte LSB first, 7-bit codes LSB first.
  assign ctl_blk[0] = 1'b1;
  assign ctl_blk[1] = 1'b0;
  assign ctl_blk[HDRW +: CHW] = TYPE_ALLCTL;
  assign err_blk[0] = 1'b1;
  assign err_blk[1] = 1'b0;
  assign err_blk[HDRW +: CHW] = TYPE_ALLCTL;

  for (genvar j = 0; j < NL; j++) begin : g_fld
    assign ctl_blk[CODE_BASE + j*CODEW +: CODEW] = codes_i[j*CODEW +: CODEW];
    assign err_blk[CODE_BASE + j*CODEW +: CODEW] = CODE_ERR;
  end

  always_comb begin
    case (kind_i)
      KIND_DATA: blk_o = data_blk;
      KIND_CTL:  blk_o = ctl_blk;
      default:   blk_o = err_blk;
    endcase
  end
endmodule

// File: rtl/enc64_ctl_blk_enc.sv
module enc64_ctl_blk_enc
  import enc64_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  vld_i,
  input  logic [LANES*CHW-1:0]  data_i,
  input  logic [LANES-1:0]      ctl_i,
  output logic                  vld_o,
  output logic [BLKW-1:0]       blk_o
);
  logic [LANES*CODEW-1:0] codes;
  logic [LANES-1:0]       known;
  blk_kind_e              kind;
  logic                   all_data_w;
  logic                   all_ctl_w;
  logic                   mixed_w;
  logic [BLKW-1:0]        blk_nxt;

  enc64_lane_map #(.NL(LANES)) u_map (
    .chars_i (data_i),
    .codes_o (codes),
    .known_o (known)
  );

  enc64_kind #(.NL(LANES)) u_kind (
    .ctl_i      (ctl_i),
    .kind_o     (kind),
    .all_data_o (all_data_w),
    .all_ctl_o  (all_ctl_w),
    .mixed_o    (mixed_w)
  );

  enc64_pack #(.NL(LANES)) u_pack (
    .kind_i  (kind),
    .data_i  (data_i),
    .codes_i (codes),
    .blk_o   (blk_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      blk_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) blk_o <= blk_nxt;
    end
  end

  // R1
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> vld_o);
  // R1
  vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> !vld_o);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> $stable(blk_o));
  // R10
  hdr_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> (blk_o[0] != blk_o[1]));
  // R3
  data_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && all_data_w) |=> (blk_o[BLKW-1:HDRW] == $past(data_i) && blk_o[1:0] == 2'b10));
  // R4
  ctl_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && all_ctl_w) |=> (blk_o[1:0] == 2'b01 && blk_o[HDRW +: CHW] == TYPE_ALLCTL));
  // R8
  mixed_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && mixed_w) |=> (blk_o[BLKW-1:HDRW+CHW] == {LANES{CODE_ERR}} && blk_o[1:0] == 2'b01));
  // R7
  known_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && all_ctl_w && known[0] && data_i[7:0] == 8'h07) |=> (blk_o[16:10] == 7'h00));
endmodule

// File: tb/tb_enc64_ctl_blk_enc.sv
module tb_enc64_ctl_blk_enc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld_i = 1'b0;
  logic [63:0] data_i = '0;
  logic [7:0]  ctl_i = '0;
  logic        vld_o;
  logic [65:0] blk_o;

  int n_chk = 0;
  int n_err = 0;
  logic        exp_vld = 1'b0;
  logic [65:0] exp_blk = '0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  enc64_ctl_blk_enc dut (
    .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .data_i(data_i),
    .ctl_i(ctl_i), .vld_o(vld_o), .blk_o(blk_o)
  );

  byte unsigned chars[8] = '{8'h07, 8'hFE, 8'h1C, 8'h3C, 8'h7C, 8'hBC, 8'hDC, 8'hF7};
  int           codev[8] = '{0, 30, 45, 51, 75, 85, 102, 120};

  function automatic int code_of(input byte unsigned c);
    for (int k = 0; k < 8; k++) if (chars[k] == c) return codev[k];
    return 30;
  endfunction

  // Serial model: append bits one at a time in line order.
  function automatic logic [65:0] model(input logic [63:0] d, input logic [7:0] c);
    logic [65:0] b;
    int pos;
    int cd;
    b = '0;
    pos = 0;
    if (c == 8'h00) begin
      b[pos++] = 1'b0; b[pos++] = 1'b1;
      for (int j = 0; j < 8; j++)
        for (int i = 0; i < 8; i++) b[pos++] = d[8*j+i];
    end else begin
      b[pos++] = 1'b1; b[pos++] = 1'b0;
      for (int i = 0; i < 8; i++) b[pos++] = ((30 >> i) & 1) != 0;
      for (int j = 0; j < 8; j++) begin
        cd = (c == 8'hFF) ? code_of(d[8*j +: 8]) : 30;
        for (int i = 0; i < 7; i++) b[pos++] = ((cd >> i) & 1) != 0;
      end
    end
    return b;
  endfunction

  task automatic check(input string req, input logic [65:0] act, input logic [65:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive a word at the falling edge; compare the previous word's result first.
  task automatic step(input string req, input logic v, input logic [63:0] d, input logic [7:0] c);
    @(negedge clk);
    check({req, " vld"}, {65'd0, vld_o}, {65'd0, exp_vld});
    check(req, blk_o, exp_blk);
    vld_i = v; data_i = d; ctl_i = c;
    exp_vld = v;
    if (v) exp_blk = model(d, c);
  endtask

  function automatic logic [63:0] pack_chars(input byte unsigned l[8]);
    logic [63:0] r;
    for (int j = 0; j < 8; j++) r[8*j +: 8] = l[j];
    return r;
  endfunction

  initial begin : wd
    repeat (50000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    logic [63:0] w;
    logic [65:0] lst;
    byte unsigned vec[8];
    repeat (3) @(negedge clk);
    // R2 reset state
    check("R2 reset vld", {65'd0, vld_o}, 66'd0);
    check("R2 reset blk", blk_o, 66'd0);
    rst_n = 1'b1;

    // R6 listed vector, compared against the byte listing
    w = pack_chars(chars);
    step("R6 setup", 1'b1, w, 8'hFF);
    @(negedge clk);
    vec = '{8'h1e, 8'h00, 8'h4f, 8'h6b, 8'hb6, 8'hac, 8'h9a, 8'hf1};
    lst[0] = 1'b1; lst[1] = 1'b0;
    for (int k = 0; k < 8; k++) lst[2+8*k +: 8] = vec[k];
    check("R6 listed vector", blk_o, lst);
    check("R4 type bits 01111000", {58'd0, blk_o[9:2]}, {58'd0, 8'b00011110});

    // R5 each character in all lanes
    for (int k = 0; k < 8; k++) begin
      for (int j = 0; j < 8; j++) vec[j] = chars[k];
      step("R5 char map", 1'b1, pack_chars(vec), 8'hFF);
    end
    // R3 all-data words
    step("R3 data", 1'b1, 64'h0123456789ABCDEF, 8'h00);
    step("R3 data", 1'b1, 64'hFEFEFEFE07070707, 8'h00);
    // R9 idle cycles hold output
    step("R9 idle", 1'b0, 64'hDEADBEEFDEADBEEF, 8'hFF);
    step("R9 idle", 1'b0, 64'h0, 8'h0F);
    // R7 unknown characters in lanes 2 and 7
    vec = '{8'h07, 8'hFE, 8'h00, 8'h3C, 8'h7C, 8'hBC, 8'hDC, 8'h55};
    step("R7 unknown char", 1'b1, pack_chars(vec), 8'hFF);
    // R8 mixed words
    step("R8 mixed", 1'b1, pack_chars(chars), 8'h01);
    step("R8 mixed", 1'b1, 64'h1111111111111111, 8'h80);
    step("R1 latency", 1'b0, 64'h0, 8'h00);
    // Random traffic, R10 and R1 observed each cycle
    for (int n = 0; n < 300; n++) begin
      for (int j = 0; j < 8; j++)
        vec[j] = ($urandom_range(0, 3) == 0) ? 8'($urandom) : chars[$urandom_range(0, 7)];
      case ($urandom_range(0, 3))
        0: step("R3 random data", 1'($urandom_range(0, 3) != 0), {$urandom, $urandom}, 8'h00);
        1: step("R8 random mixed", 1'($urandom_range(0, 3) != 0), pack_chars(vec), 8'($urandom_range(1, 254)));
        default: step("R5 random ctl", 1'($urandom_range(0, 3) != 0), pack_chars(vec), 8'hFF);
      endcase
      if (vld_i) begin
        @(negedge clk);
        check("R10 header", {64'd0, blk_o[1:0] == 2'b00 || blk_o[1:0] == 2'b11}, 66'd0);
        vld_i = 1'b0;
        exp_vld = 1'b0;
      end
    end
    step("R1 final", 1'b0, 64'h0, 8'h00);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    done = 1'b1;
    $finish;
  end
endmodule